// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It fetches a directory entry and then, when needed, a table entry through one 32-bit memory port. A caller presents an address along with the access kind (read or write) and the current privilege level. After one or more memory transactions the walker returns a physical address or a fault. While paging is off, the address goes straight through as the physical address and no memory is touched.

Two page sizes are supported. A walk normally ends at a table entry that maps a 4 KB page. When the large-page enable is set and the directory entry carries its size flag, the walk stops at the directory entry, which maps a 4 MB page. The walker keeps the in-memory entries up to date: it writes an entry back with its accessed flag set the first time the entry is used, and it marks the final entry dirty on a write. It applies the present, writable and supervisor-only flags, and a fault says which of them stopped the access.

Top module: `ptw_walker`

## Requirements
- R1: With cfg_paging_en low, an accepted request completes one cycle after acceptance with rsp_paddr equal to req_vaddr, rsp_fault low and no memory transaction.
- R2: In a 4 KB walk the directory entry is read at {cfg_dir_frame, va[31:22], 2'b00} and the table entry at {pde[31:12], va[21:12], 2'b00}, giving rsp_paddr = {pte[31:12], va[11:0]}.
- R3: With cfg_large_en high and directory bit 7 set, no table entry is read and rsp_paddr = {pde[31:22], va[21:0]}; with cfg_large_en low, bit 7 is ignored and a 4 KB walk follows.
- R4: A used entry whose accessed flag (bit 5) is clear is written back to the address it was read from with bit 5 set; an entry with bit 5 already set is not written unless R5 needs it.
- R5: On a write access the final entry (table entry, or directory entry of a 4 MB page) gets its dirty flag (bit 6) set by write-back; a directory entry that points to a table never gets bit 6 set by the walker.
- R6: An entry with present flag (bit 0) clear ends the walk with rsp_fault high and flt_present low, and no further memory transaction follows.
- R7: A write access to an entry whose writable flag (bit 1) is clear, at either level, faults with flt_present high and flt_write high.
- R8: When req_cpl is 3, an entry whose user flag (bit 2) is clear faults with flt_user high; privilege levels 0 to 2 pass this check.
- R9: A fault reports flt_write equal to the access kind and flt_user equal to (req_cpl == 3), and the faulting entry is not written back; on success all three fault flags are low.
- R10: mem_req stays high with mem_addr, mem_we and mem_wdata stable until mem_ack, one transaction at a time; mem_req is low whenever busy is low.
- R11: busy is high from acceptance until the cycle done pulses for one cycle with the result; req_valid while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken when busy is low) |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_cpl | input | 2 | Current privilege level, 3 = user |
| cfg_dir_frame | input | 20 | Frame number of the page directory |
| cfg_paging_en | input | 1 | Enable translation |
| cfg_large_en | input | 1 | Enable 4 MB pages |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = entry read |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Transaction complete (read data valid) |
| mem_rdata | input | 32 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Translation faulted |
| flt_present | output | 1 | Fault was on a present entry |
| flt_write | output | 1 | Faulting access was a write |
| flt_user | output | 1 | Faulting access came from privilege level 3 |

## Verification
A wrong walk state or a stale latched frame shows on the memory port before it shows anywhere else: the next transaction carries the wrong address, kind or data, or a transaction is missing or extra. The reference model predicts every transaction in order, so the mismatch is caught on the cycle that transaction is served. A wrong permission or flag decision shows at done as a wrong fault flag or physical address, at most one cycle after the last memory acknowledge. The write-backs change the bench memory, so a repeat walk also shows whether the earlier write-back stored the right value.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int BIT_PRES  = 0;
  localparam int BIT_WR    = 1;
  localparam int BIT_USR   = 2;
  localparam int BIT_WTHR  = 3;
  localparam int BIT_NOCA  = 4;
  localparam int BIT_ACC   = 5;
  localparam int BIT_DIRTY = 6;
  localparam int BIT_BIG   = 7;
  localparam int BIT_GLOB  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WB_DIR,
    ST_RD_TBL,
    ST_WB_TBL
  } walk_st_t;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 12,
  parameter int IDX_W     = 10,
  parameter int ENT_SHIFT = 2,
  localparam int FRAME_W  = ADDR_W - OFS_W
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [IDX_W-1:0]   idx,
  output logic [ADDR_W-1:0]  addr
);
  always_comb begin
    addr = {frame, {OFS_W{1'b0}}} + (ADDR_W'(idx) << ENT_SHIFT);
  end
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk (
  input  logic pres,
  input  logic wr_ok,
  input  logic usr_ok,
  input  logic is_write,
  input  logic is_user,
  output logic fault
);
  always_comb begin
    fault = !pres || (is_write && !wr_ok) || (is_user && !usr_ok);
  end
endmodule

// File: rtl/ptw_flag_upd.sv
module ptw_flag_upd
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] ent_in,
  input  logic             set_dirty,
  output logic             need_wb,
  output logic [ENT_W-1:0] ent_out
);
  always_comb begin
    ent_out = ent_in;
    ent_out[BIT_ACC] = 1'b1;
    if (set_dirty) ent_out[BIT_DIRTY] = 1'b1;
    need_wb = !ent_in[BIT_ACC] || (set_dirty && !ent_in[BIT_DIRTY]);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 12,
  parameter int IDX_W     = 10,
  parameter int ENT_SHIFT = 2,
  localparam int FRAME_W  = ADDR_W - OFS_W,
  localparam int LOFS_W   = IDX_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_write,
  input  logic [1:0]         req_cpl,
  input  logic [FRAME_W-1:0] cfg_dir_frame,
  input  logic               cfg_paging_en,
  input  logic               cfg_large_en,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ADDR_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [ADDR_W-1:0]  mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [ADDR_W-1:0]  rsp_paddr,
  output logic               rsp_fault,
  output logic               flt_present,
  output logic               flt_write,
  output logic               flt_user
);
  walk_st_t             st_q;
  logic [ADDR_W-1:0]    va_q;
  logic                 wr_q, usr_q, big_en_q, big_q;
  logic [FRAME_W-1:0]   frame_q;

  logic [ADDR_W-1:0]    dir_addr, tbl_addr, upd_ent;
  logic [FRAME_W-1:0]   cur_frame;
  logic                 rd_state, at_dir, is_big, final_lvl;
  logic                 chk_fault, upd_need;
  logic [ADDR_W-1:0]    big_paddr, small_paddr;

  assign rd_state  = (st_q == ST_RD_DIR) || (st_q == ST_RD_TBL);
  assign at_dir    = (st_q == ST_RD_DIR);
  assign cur_frame = rd_state ? mem_rdata[ADDR_W-1:OFS_W] : frame_q;
  assign is_big    = big_en_q && mem_rdata[BIT_BIG];
  assign final_lvl = at_dir ? is_big : 1'b1;
  assign big_paddr   = {cur_frame[FRAME_W-1:IDX_W], va_q[LOFS_W-1:0]};
  assign small_paddr = {cur_frame, va_q[OFS_W-1:0]};

  ptw_entry_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .ENT_SHIFT(ENT_SHIFT)) u_dir_addr (
    .frame (cfg_dir_frame),
    .idx   (req_vaddr[ADDR_W-1 -: IDX_W]),
    .addr  (dir_addr)
  );

  ptw_entry_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .ENT_SHIFT(ENT_SHIFT)) u_tbl_addr (
    .frame (cur_frame),
    .idx   (va_q[LOFS_W-1 -: IDX_W]),
    .addr  (tbl_addr)
  );

  ptw_perm_chk u_chk (
    .pres     (mem_rdata[BIT_PRES]),
    .wr_ok    (mem_rdata[BIT_WR]),
    .usr_ok   (mem_rdata[BIT_USR]),
    .is_write (wr_q),
    .is_user  (usr_q),
    .fault    (chk_fault)
  );

  ptw_flag_upd #(.ENT_W(ADDR_W)) u_upd (
    .ent_in    (mem_rdata),
    .set_dirty (wr_q && final_lvl),
    .need_wb   (upd_need),
    .ent_out   (upd_ent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      big_en_q    <= 1'b0;
      big_q       <= 1'b0;
      frame_q     <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      done        <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault   <= 1'b0;
      flt_present <= 1'b0;
      flt_write   <= 1'b0;
      flt_user    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            wr_q     <= req_write;
            usr_q    <= (req_cpl == 2'd3);
            big_en_q <= cfg_large_en;
            if (!cfg_paging_en) begin
              done        <= 1'b1;
              rsp_paddr   <= req_vaddr;
              rsp_fault   <= 1'b0;
              flt_present <= 1'b0;
              flt_write   <= 1'b0;
              flt_user    <= 1'b0;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= dir_addr;
              st_q     <= ST_RD_DIR;
            end
          end
        end
        ST_RD_DIR, ST_RD_TBL: begin
          if (mem_ack) begin
            frame_q <= cur_frame;
            big_q   <= at_dir && is_big;
            if (chk_fault) begin
              mem_req     <= 1'b0;
              done        <= 1'b1;
              rsp_fault   <= 1'b1;
              rsp_paddr   <= '0;
              flt_present <= mem_rdata[BIT_PRES];
              flt_write   <= wr_q;
              flt_user    <= usr_q;
              st_q        <= ST_IDLE;
            end else if (upd_need) begin
              mem_we    <= 1'b1;
              mem_wdata <= upd_ent;
              st_q      <= at_dir ? ST_WB_DIR : ST_WB_TBL;
            end else if (at_dir && !is_big) begin
              mem_addr <= tbl_addr;
              st_q     <= ST_RD_TBL;
            end else begin
              mem_req     <= 1'b0;
              done        <= 1'b1;
              rsp_fault   <= 1'b0;
              rsp_paddr   <= (at_dir) ? big_paddr : small_paddr;
              flt_present <= 1'b0;
              flt_write   <= 1'b0;
              flt_user    <= 1'b0;
              st_q        <= ST_IDLE;
            end
          end
        end
        ST_WB_DIR, ST_WB_TBL: begin
          if (mem_ack) begin
            if (st_q == ST_WB_DIR && !big_q) begin
              mem_we   <= 1'b0;
              mem_addr <= tbl_addr;
              st_q     <= ST_RD_TBL;
            end else begin
              mem_req     <= 1'b0;
              mem_we      <= 1'b0;
              done        <= 1'b1;
              rsp_fault   <= 1'b0;
              rsp_paddr   <= big_q ? big_paddr : small_paddr;
              flt_present <= 1'b0;
              flt_write   <= 1'b0;
              flt_user    <= 1'b0;
              st_q        <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              cfg_paging_en,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic              flt_present,
  input logic              flt_write,
  input logic              flt_user
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R10

  AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    req_valid && !busy && !cfg_paging_en |=> done && !rsp_fault && rsp_paddr == $past(req_vaddr)); // R1

  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[5]); // R4

  AST_CLEAN_FLAGS: assert property (@(posedge clk) disable iff (rst)
    done && !rsp_fault |-> !flt_present && !flt_write && !flt_user); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_walker_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .cfg_paging_en(cfg_paging_en), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .busy(busy), .done(done), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .flt_present(flt_present), .flt_write(flt_write), .flt_user(flt_user)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_cpl = 2'd0;
  logic [19:0] cfg_dir_frame = 20'h00010;
  logic        cfg_paging_en = 1'b0;
  logic        cfg_large_en = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, rsp_fault, flt_present, flt_write, flt_user;
  logic [31:0] rsp_paddr;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_cpl(req_cpl), .cfg_dir_frame(cfg_dir_frame),
    .cfg_paging_en(cfg_paging_en), .cfg_large_en(cfg_large_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .flt_present(flt_present),
    .flt_write(flt_write), .flt_user(flt_user)
  );

  logic [31:0] mem [logic [31:0]];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  bit          q_we[$];

  logic [31:0] exp_paddr;
  bit          exp_fault, exp_fp, exp_fw, exp_fu;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench memory: one transaction served per request, ack one cycle later
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (q_addr.size() == 0) begin
        chk(1'b0, "R10", "unexpected memory access", mem_addr, 32'hFFFFFFFF);
      end else begin
        logic [31:0] ea, ed;
        bit ew;
        ea = q_addr.pop_front(); ed = q_data.pop_front(); ew = q_we.pop_front();
        chk(mem_addr == ea, "R2", "access address", mem_addr, ea);
        chk(mem_we == ew, "R4", "access kind", {31'b0, mem_we}, {31'b0, ew});
        if (ew) chk(mem_wdata == ed, "R5", "write-back value", mem_wdata, ed);
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= rd(mem_addr);
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // behavioural reference of one walk
  task automatic model(input logic [31:0] va, input bit wr, input logic [1:0] cpl);
    logic [31:0] da, ta, d, t, nd, nt;
    bit usr, big;
    exp_fault = 0; exp_fp = 0; exp_fw = 0; exp_fu = 0;
    if (!cfg_paging_en) begin exp_paddr = va; return; end
    usr = (cpl == 2'd3);
    da = {cfg_dir_frame, 12'h0} + va[31:22] * 4;
    q_addr.push_back(da); q_data.push_back(0); q_we.push_back(0);
    d = rd(da);
    if (!d[0] || (wr && !d[1]) || (usr && !d[2])) begin
      exp_fault = 1; exp_fp = d[0]; exp_fw = wr; exp_fu = usr; exp_paddr = 0; return;
    end
    big = cfg_large_en && d[7];
    nd = d | 32'h20 | ((big && wr) ? 32'h40 : 32'h0);
    if (nd != d) begin q_addr.push_back(da); q_data.push_back(nd); q_we.push_back(1); end
    if (big) begin exp_paddr = {d[31:22], va[21:0]}; return; end
    ta = {d[31:12], 12'h0} + va[21:12] * 4;
    q_addr.push_back(ta); q_data.push_back(0); q_we.push_back(0);
    t = rd(ta);
    if (!t[0] || (wr && !t[1]) || (usr && !t[2])) begin
      exp_fault = 1; exp_fp = t[0]; exp_fw = wr; exp_fu = usr; exp_paddr = 0; return;
    end
    nt = t | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (nt != t) begin q_addr.push_back(ta); q_data.push_back(nt); q_we.push_back(1); end
    exp_paddr = {t[31:12], va[11:0]};
  endtask

  task automatic walk(input string tag, input logic [31:0] va, input bit wr,
                      input logic [1:0] cpl, input bit poke_busy);
    int waited;
    @(negedge clk);
    model(va, wr, cpl);
    req_vaddr = va; req_write = wr; req_cpl = cpl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    if (poke_busy && busy) begin
      req_vaddr = 32'hDEAD_BEEF; req_write = 1'b1; req_cpl = 2'd3; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      waited++;
    end
    while (!done && waited < 200) begin @(negedge clk); waited++; end
    if (!cfg_paging_en) chk(waited == 0, "R1", {tag, " latency"}, waited, 0);
    chk(done == 1'b1, "R11", {tag, " done"}, {31'b0, done}, 32'h1);
    chk(busy == 1'b0, "R11", {tag, " busy at done"}, {31'b0, busy}, 32'h0);
    chk(rsp_fault == exp_fault, "R6", {tag, " fault"}, {31'b0, rsp_fault}, {31'b0, exp_fault});
    if (!exp_fault) chk(rsp_paddr == exp_paddr, "R2", {tag, " paddr"}, rsp_paddr, exp_paddr);
    chk({flt_present, flt_write, flt_user} == {exp_fp, exp_fw, exp_fu}, "R9", {tag, " fault flags"},
        {29'b0, flt_present, flt_write, flt_user}, {29'b0, exp_fp, exp_fw, exp_fu});
    chk(q_addr.size() == 0, "R10", {tag, " accesses left"}, q_addr.size(), 0);
    q_addr.delete(); q_data.delete(); q_we.delete();
    @(negedge clk);
    chk(done == 1'b0, "R11", {tag, " done one cycle"}, {31'b0, done}, 32'h0);
  endtask

  initial begin
    // directory at frame 0x00010
    mem[32'h0001_0004] = 32'h0002_0007;  // idx1 -> table at 0x20000, user, writable
    mem[32'h0002_000C] = 32'h0ABC_D007;  // 4 KB page
    mem[32'h0002_0014] = 32'h0033_3005;  // read-only page
    mem[32'h0001_0008] = 32'h0C00_0087;  // idx2: size flag set
    mem[32'h0C00_0048] = 32'h0000_5007;  // used when large pages off
    mem[32'h0001_0010] = 32'h0003_0003;  // idx4: supervisor only
    mem[32'h0003_0000] = 32'h0044_4003;

    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R11", "reset outputs",
        {29'b0, busy, done, mem_req}, 32'h0);
    rst = 1'b0;

    walk("R1 passthrough", 32'h1234_5678, 1'b1, 2'd3, 1'b0);
    cfg_paging_en = 1'b1;
    walk("R2 R4 first read", 32'h0040_3ABC, 1'b0, 2'd3, 1'b0);
    walk("R4 accessed already set", 32'h0040_3ABC, 1'b0, 2'd3, 1'b0);
    chk(rd(32'h0002_000C) == 32'h0ABC_D027, "R4", "table entry after use", rd(32'h0002_000C), 32'h0ABC_D027);
    walk("R5 write dirty", 32'h0040_3FFF, 1'b1, 2'd3, 1'b0);
    chk(rd(32'h0001_0004) == 32'h0002_0027, "R5", "directory stays clean", rd(32'h0001_0004), 32'h0002_0027);
    walk("R3 small when disabled", 32'h0081_2345, 1'b0, 2'd0, 1'b0);
    cfg_large_en = 1'b1;
    walk("R3 large write", 32'h0081_2345, 1'b1, 2'd0, 1'b0);
    chk(rd(32'h0001_0008) == 32'h0C00_00E7, "R5", "large entry dirty", rd(32'h0001_0008), 32'h0C00_00E7);
    walk("R6 dir absent", 32'h00C0_0000, 1'b0, 2'd0, 1'b0);
    walk("R6 table absent", 32'h0040_4000, 1'b1, 2'd3, 1'b0);
    walk("R7 read-only write", 32'h0040_5010, 1'b1, 2'd0, 1'b0);
    walk("R7 read-only read", 32'h0040_5010, 1'b0, 2'd3, 1'b0);
    walk("R8 user on supervisor", 32'h0100_0010, 1'b0, 2'd3, 1'b0);
    chk(rd(32'h0001_0010) == 32'h0003_0003, "R9", "no write-back on fault", rd(32'h0001_0010), 32'h0003_0003);
    walk("R8 level 2 on supervisor", 32'h0100_0010, 1'b1, 2'd2, 1'b0);
    walk("R11 ignored while busy", 32'h0040_3123, 1'b0, 2'd0, 1'b1);
    cfg_paging_en = 1'b0;
    walk("R1 passthrough read", 32'hFFFF_0001, 1'b0, 2'd0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule